// File: doc/BRIEF.md
# Store Drain Queue with Read Bypass

This block sits between a write-through cache and main memory. Every store the processor sends to the cache is also pushed here as an address/data pair. The queue hands its oldest pair to the memory write port whenever memory accepts it, so the processor does not wait on slow memory writes.

Read misses headed for memory pass through the block first. In the same cycle, the read address is compared against every occupied slot. If any slot holds that address, the block supplies the data of the most recently queued matching store and withholds the memory read. Without this, the read could return stale memory contents while the newer value still waits in the queue. If no slot matches, the read request goes on to memory unchanged.

When stores arrive faster than memory drains them, the queue fills and the store side is held off until a slot frees up.

Top module: `wrbuf_fwd`

## Requirements
- R1: After a synchronous active-high reset the queue is empty: `empty`=1, `full`=0, `st_ready`=1, `mem_wr_valid`=0.
- R2: `mem_wr_valid` is high whenever at least one slot is occupied. `mem_wr_addr`/`mem_wr_data` show the oldest queued store and hold steady until `mem_wr_ready` is high at a clock edge, which removes it.
- R3: A store is taken when `st_valid` and `st_ready` are both high at a clock edge. It reaches the memory write port only after every store taken before it.
- R4: The queue holds DEPTH (default 4) stores. `st_ready` is low when all slots are occupied and `mem_wr_ready` is low. It is high when all slots are occupied and `mem_wr_ready` is high.
- R5: A store taken in the same cycle as a drain leaves the occupancy unchanged, and both stores keep their order.
- R6: A read (`rd_req`=1) whose address equals any occupied slot's address gives `rd_hit`=1 and `mem_rd_req`=0 in that same cycle, with the slot's data on `rd_data`.
- R7: A read that matches no occupied slot gives `rd_hit`=0 and `mem_rd_req`=1, with `mem_rd_addr` equal to `rd_addr`, in that same cycle.
- R8: When several occupied slots match a read, `rd_data` comes from the one queued last.
- R9: A slot being drained in the cycle of a read still counts as a match.
- R10: A store presented in the same cycle as a read is not searched by that read.
- R11: `full` is high exactly when DEPTH slots are occupied. `empty` is high exactly when none are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request from the processor side |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Queue can take a store this cycle |
| mem_wr_valid | output | 1 | Oldest store offered to memory |
| mem_wr_addr | output | 32 | Address of the oldest store |
| mem_wr_data | output | 32 | Data of the oldest store |
| mem_wr_ready | input | 1 | Memory takes the offered store |
| rd_req | input | 1 | Read miss heading for memory |
| rd_addr | input | 32 | Read address |
| rd_hit | output | 1 | Read served from the queue |
| rd_data | output | 32 | Forwarded data on a hit |
| mem_rd_req | output | 1 | Read passed on to memory |
| mem_rd_addr | output | 32 | Address of the passed-on read |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |

## Verification
The assertions run on every cycle. They check that:
- the occupancy moves by exactly one for each push and pop;
- no store is taken into a full queue unless a slot drains at the same edge;
- the offered memory write holds still while memory stalls;
- a read never hits an empty queue;
- `full` and `empty` never appear together.

Other properties depend on the data the queue holds, so only the bench's scenarios, compared against a queue-based model, can show them:
- the drain order;
- the choice of the newest among duplicate addresses;
- a hit on a slot leaving in the same cycle;
- a same-cycle store staying invisible to a read.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    localparam int unsigned WB_AW = 32;
    localparam int unsigned WB_DW = 32;

    typedef struct packed {
        logic [WB_AW-1:0] addr;
        logic [WB_DW-1:0] data;
    } wb_entry_t;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  wb_entry_t             push_ent,
    input  logic                  pop,
    output wb_entry_t             head,
    output wb_entry_t [DEPTH-1:0] slots,
    output logic      [PW-1:0]    rd_ptr,
    output logic      [CW-1:0]    count
);
    logic [PW-1:0] wr_ptr;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign head = slots[rd_ptr];

    // R4: a full queue takes a store only while a slot leaves
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (push && count == CW'(DEPTH)) |-> pop);

    // R5: occupancy tracks pushes and pops exactly
    p_occupancy_r5: assert property (@(posedge clk)
        (!rst) |=> (rst || count == $past(count) + CW'($past(push)) - CW'($past(pop))));
endmodule

// File: rtl/wbuf_lookup.sv
module wbuf_lookup
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  wb_entry_t [DEPTH-1:0] slots,
    input  logic      [PW-1:0]    rd_ptr,
    input  logic      [CW-1:0]    count,
    input  logic      [WB_AW-1:0] q_addr,
    output logic                  hit,
    output logic      [WB_DW-1:0] data
);
    // Walk the slots from oldest to newest; a later match overrides an earlier one.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (k < int'(count) &&
                slots[(int'(rd_ptr) + k) % DEPTH].addr == q_addr) begin
                hit  = 1'b1;
                data = slots[(int'(rd_ptr) + k) % DEPTH].data;
            end
        end
    end
endmodule

// File: rtl/wrbuf_fwd.sv
module wrbuf_fwd
    import wbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    input  logic [WB_AW-1:0] st_addr,
    input  logic [WB_DW-1:0] st_data,
    output logic             st_ready,
    output logic             mem_wr_valid,
    output logic [WB_AW-1:0] mem_wr_addr,
    output logic [WB_DW-1:0] mem_wr_data,
    input  logic             mem_wr_ready,
    input  logic             rd_req,
    input  logic [WB_AW-1:0] rd_addr,
    output logic             rd_hit,
    output logic [WB_DW-1:0] rd_data,
    output logic             mem_rd_req,
    output logic [WB_AW-1:0] mem_rd_addr,
    output logic             full,
    output logic             empty
);
    wb_entry_t             head, push_ent;
    wb_entry_t [DEPTH-1:0] slots;
    logic      [PW-1:0]    rd_ptr;
    logic      [CW-1:0]    count;
    logic                  push, pop, lk_hit;
    logic      [WB_DW-1:0] lk_data;

    assign full         = (count == CW'(DEPTH));
    assign empty        = (count == '0);
    assign st_ready     = !full || mem_wr_ready;
    assign mem_wr_valid = !empty;
    assign push         = st_valid && st_ready;
    assign pop          = mem_wr_valid && mem_wr_ready;
    assign push_ent     = '{addr: st_addr, data: st_data};
    assign mem_wr_addr  = head.addr;
    assign mem_wr_data  = head.data;

    wbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .push(push), .push_ent(push_ent), .pop(pop),
        .head(head), .slots(slots), .rd_ptr(rd_ptr), .count(count)
    );

    wbuf_lookup #(.DEPTH(DEPTH)) u_lookup (
        .slots(slots), .rd_ptr(rd_ptr), .count(count), .q_addr(rd_addr),
        .hit(lk_hit), .data(lk_data)
    );

    assign rd_hit      = rd_req && lk_hit;
    assign rd_data     = lk_data;
    assign mem_rd_req  = rd_req && !lk_hit;
    assign mem_rd_addr = rd_addr;

    // R2: a stalled memory write keeps its address and data
    p_head_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

    // R6: an empty queue cannot serve a read
    p_empty_nohit_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && empty) |-> (!rd_hit && mem_rd_req));

    // R11: the two occupancy flags exclude each other
    p_flags_r11: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
endmodule

// File: tb/sim_wrbuf_fwd.sv
`timescale 1ns/1ps
module sim_wrbuf_fwd;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst, st_valid, st_ready, mem_wr_valid, mem_wr_ready;
    logic        rd_req, rd_hit, mem_rd_req, full, empty;
    logic [31:0] st_addr, st_data, mem_wr_addr, mem_wr_data;
    logic [31:0] rd_addr, rd_data, mem_rd_addr;

    wrbuf_fwd u0 (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_ready(st_ready), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .full(full), .empty(empty)
    );

    typedef struct { logic [31:0] a; logic [31:0] d; } ent_t;
    ent_t  q[$];
    int    n_chk = 0, n_fail = 0;
    string phase = "init";
    logic [31:0] lfsr = 32'hACE1_2468;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %h expected %h", req, phase, what, act, exp);
        end
    endtask

    // Compare every output with the model for the inputs now applied
    task automatic compare();
        bit found = 0;
        logic [31:0] fd = '0;
        bit e_full  = (q.size() == 4);
        bit e_empty = (q.size() == 0);
        chk("R4",  32'(st_ready), 32'(!e_full || mem_wr_ready), "st_ready");
        chk("R11", 32'(full), 32'(e_full), "full");
        chk("R11", 32'(empty), 32'(e_empty), "empty");
        chk("R2",  32'(mem_wr_valid), 32'(!e_empty), "mem_wr_valid");
        if (!e_empty) begin
            chk("R2", mem_wr_addr, q[0].a, "mem_wr_addr");
            chk("R3", mem_wr_data, q[0].d, "mem_wr_data");
        end
        for (int i = q.size() - 1; i >= 0; i--)
            if (!found && q[i].a == rd_addr) begin found = 1; fd = q[i].d; end
        chk("R6", 32'(rd_hit), 32'(rd_req && found), "rd_hit");
        if (rd_req && found) chk("R8", rd_data, fd, "rd_data");
        chk("R7", 32'(mem_rd_req), 32'(rd_req && !found), "mem_rd_req");
        if (rd_req) chk("R7", mem_rd_addr, rd_addr, "mem_rd_addr");
    endtask

    task automatic step(input logic sv, input logic [31:0] sa, input logic [31:0] sd,
                        input logic mr, input logic rr, input logic [31:0] ra);
        bit acc, drn;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd;
        mem_wr_ready = mr; rd_req = rr; rd_addr = ra;
        #1;
        compare();
        acc = sv && ((q.size() < 4) || mr);
        drn = (q.size() > 0) && mr;
        @(posedge clk);
        if (drn) void'(q.pop_front());
        if (acc) q.push_back('{a: sa, d: sd});
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1; st_valid = 0; st_addr = 0; st_data = 0;
        mem_wr_ready = 0; rd_req = 0; rd_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        phase = "R1 reset";
        chk("R1", 32'(empty), 1, "empty");
        chk("R1", 32'(full), 0, "full");
        chk("R1", 32'(st_ready), 1, "st_ready");
        chk("R1", 32'(mem_wr_valid), 0, "mem_wr_valid");

        phase = "R3 fill in order";
        step(1, 32'h100, 32'hA0, 0, 1, 32'h100);
        step(1, 32'h104, 32'hA1, 0, 1, 32'h100);
        step(1, 32'h100, 32'hA2, 0, 1, 32'h104);
        step(1, 32'h108, 32'hA3, 0, 0, 0);

        phase = "R4 full refuses store";
        step(1, 32'h10C, 32'hBAD, 0, 1, 32'h10C);
        step(0, 0, 0, 0, 1, 32'h10C);

        phase = "R8 newest duplicate";
        step(0, 0, 0, 0, 1, 32'h100);
        phase = "R7 miss goes to memory";
        step(0, 0, 0, 0, 1, 32'h200);

        phase = "R5 store with drain while full";
        step(1, 32'h110, 32'hA4, 1, 0, 0);
        step(0, 0, 0, 0, 1, 32'h110);

        phase = "R9 draining slot still matches";
        step(0, 0, 0, 1, 1, 32'h104);
        step(0, 0, 0, 0, 1, 32'h104);

        phase = "R2 drain to empty";
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1, 32'h100);

        phase = "R10 same-cycle store not searched";
        step(1, 32'h300, 32'hC0, 0, 1, 32'h300);
        step(0, 0, 0, 0, 1, 32'h300);
        step(0, 0, 0, 1, 0, 0);

        phase = "mixed traffic";
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0], 32'h40 + {27'd0, lfsr[3:1], 2'b00}, lfsr ^ 32'h5A5A_0000,
                 lfsr[4] & lfsr[5], lfsr[6], 32'h40 + {27'd0, lfsr[9:7], 2'b00});
        end
        phase = "final drain";
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 1, 32'h40);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule